// File: doc/BRIEF.md
# Multi-mode DDS waveform playback engine

This block is one direct digital synthesis channel. A phase accumulator adds a programmable tuning word, plus a signed frequency offset that can change every clock, on each cycle. Three playback modes use the accumulator. In wavetable mode, the upper phase bits address an internal sample buffer, so the tuning word sets the repetition frequency and points may be skipped or repeated. In step mode, the carry out of the accumulator acts as a sample strobe: each carry advances a read pointer through the buffer by exactly one point. In stream mode, the same strobe pulls one sample from an external ready/valid stream.

Every output sample then passes through a full-rate amplitude scaler. A small register-style configuration port sets the pending mode and length code, the tuning word, the buffer write index and the buffer data. A synchronous `restart` pulse applies the pending mode and length. The same pulse clears the accumulator, the read pointer, the output pipeline and the underflow flag.

Top module: `dds_playback_engine`

## Requirements
- R1: While `rst_n` is low, and after it rises, `sample_out` is 0, `underflow` is 0 and `s_ready` is 0. The active mode is wavetable and the length code is 0.
- R2: In wavetable mode, with the restart edge counted as edge 0, `sample_out` after edge n (n >= 3) is the scaled buffer entry whose index is the top L bits of (n-3)*step mod 2^32. Here step is the per-cycle phase increment. With step = ceil(2^32/250), the output wraps exactly 10 times in 2500 samples, so 250 MSa/s gives 1 MHz.
- R3: The 2-bit length code c selects a length of 2^L points, where L = 10 + c. L is clamped to the buffer size (2048 points by default), so codes 1, 2 and 3 all index 11 bits.
- R4: In step mode, each accumulator carry advances the read pointer by one, and the pointer wraps to 0 after length-1. `sample_out` after edge n (n >= 4) is the scaled entry at index floor((n-4)*step / 2^32) mod length. Points are never skipped.
- R5: In stream mode, `s_ready` is high only in the cycle after an accumulator carry. The sample is taken only when `s_valid` is high in that cycle, and `s_valid`/`s_data` are ignored in every other cycle. `sample_out` after edge n is the scaled version of the sample held after edge n-2.
- R6: If `s_valid` is low while `s_ready` is high, the previous sample is held and `underflow` goes high on the next edge. It stays high until `restart`.
- R7: The phase increment is the tuning word plus `fm_ofs`, sign-extended and summed modulo 2^32.
- R8: Amplitude scaling is (x*`am_scale` + 2^14) >>> 15, with both operands signed Q1.15, saturated to 16 bits. It adds two register stages.
- R9: A control write takes effect only at the next `restart`. `restart` zeroes the phase, read pointer, pipeline and `underflow`.
- R10: Configuration word map: address 0 holds the control word, with mode in bits [1:0] (0 wavetable, 1 step, 2 stream, 3 wavetable) and length code in bits [3:2]. Address 1 holds the tuning word. Address 2 sets the buffer write index. Address 3 writes data bits [15:0] at that index and then increments the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| restart | input | 1 | Synchronous restart; applies pending mode and length |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select |
| cfg_wdata | input | 32 | Configuration write data |
| fm_ofs | input | 16 | Signed per-cycle frequency offset |
| am_scale | input | 16 | Signed Q1.15 amplitude scale |
| s_valid | input | 1 | Stream sample valid |
| s_data | input | 16 | Stream sample |
| s_ready | output | 1 | Stream sample accepted this cycle if valid |
| sample_out | output | 16 | Signed output sample |
| underflow | output | 1 | Sticky stream underflow flag |

## Verification
The assertions assume that `restart` and the configuration inputs are synchronous and that the length code changes only through a restart. Under those assumptions, the read pointer can never be left beyond the active length. They also assume that `s_valid`/`s_data` matter only in ready cycles. The bench drives every input on the falling clock edge. It holds `fm_ofs` and `am_scale` constant within each run, so that each expected sample follows in closed form from the cycle count since restart. In stream mode it toggles `s_valid` outside ready cycles to show that those values are ignored.

// File: rtl/dds_pb_pkg.sv
package dds_pb_pkg;
   typedef enum logic [1:0] {
      MODE_TABLE  = 2'd0,
      MODE_STEP   = 2'd1,
      MODE_STREAM = 2'd2,
      MODE_TABLE2 = 2'd3
   } pb_mode_e;

   localparam logic [1:0] CFG_CTRL = 2'd0;
   localparam logic [1:0] CFG_TUNE = 2'd1;
   localparam logic [1:0] CFG_WIDX = 2'd2;
   localparam logic [1:0] CFG_WDAT = 2'd3;
endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
   parameter int PHASE_W = 32,
   parameter int FM_W    = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      clr,
   input  logic [PHASE_W-1:0]        tune,
   input  logic signed [FM_W-1:0]    fm_ofs,
   output logic [PHASE_W-1:0]        phase,
   output logic                      wrap
);
   logic [PHASE_W-1:0] step;
   logic [PHASE_W:0]   sum;

   always_comb begin
      step = tune + {{(PHASE_W-FM_W){fm_ofs[FM_W-1]}}, fm_ofs};
      sum  = {1'b0, phase} + {1'b0, step};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= '0;
         wrap  <= 1'b0;
      end else if (clr) begin
         phase <= '0;
         wrap  <= 1'b0;
      end else begin
         phase <= sum[PHASE_W-1:0];
         wrap  <= sum[PHASE_W];
      end
   end
endmodule

// File: rtl/dds_wave_buf.sv
module dds_wave_buf #(
   parameter int ADDR_W = 11,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   rdata <= '0;
      else if (clr) rdata <= '0;
      else          rdata <= mem[raddr];
   end
endmodule

// File: rtl/dds_amp_scale.sv
module dds_amp_scale #(
   parameter int DATA_W = 16,
   parameter bit AM_EN  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr,
   input  logic signed [DATA_W-1:0] din,
   input  logic signed [DATA_W-1:0] scale,
   output logic signed [DATA_W-1:0] dout
);
   generate
      if (AM_EN) begin : g_mul
         localparam int PW = 2 * DATA_W;
         localparam logic signed [PW:0] RND  = (PW+1)'(longint'(1) << (DATA_W-2));
         localparam logic signed [PW:0] MAXV = (PW+1)'((longint'(1) << (DATA_W-1)) - 1);
         localparam logic signed [PW:0] MINV = -MAXV - 1;

         logic signed [PW-1:0]   prod_q;
         logic signed [PW:0]     rnd;
         logic signed [PW:0]     shv;
         logic signed [DATA_W-1:0] satv;

         always_comb begin
            rnd = {prod_q[PW-1], prod_q} + RND;
            shv = rnd >>> (DATA_W-1);
            if (shv > MAXV)      satv = {1'b0, {(DATA_W-1){1'b1}}};
            else if (shv < MINV) satv = {1'b1, {(DATA_W-1){1'b0}}};
            else                 satv = shv[DATA_W-1:0];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prod_q <= '0;
               dout   <= '0;
            end else if (clr) begin
               prod_q <= '0;
               dout   <= '0;
            end else begin
               prod_q <= din * scale;
               dout   <= satv;
            end
         end
      end else begin : g_dly
         logic signed [DATA_W-1:0] d1_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               d1_q <= '0;
               dout <= '0;
            end else if (clr) begin
               d1_q <= '0;
               dout <= '0;
            end else begin
               d1_q <= din;
               dout <= d1_q;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/dds_playback_engine.sv
module dds_playback_engine
   import dds_pb_pkg::*;
#(
   parameter int PHASE_W  = 32,
   parameter int FM_W     = 16,
   parameter int SAMP_W   = 16,
   parameter int BUF_LOG2 = 11,
   parameter int MIN_LOG2 = 10,
   parameter bit AM_EN    = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     restart,
   input  logic                     cfg_we,
   input  logic [1:0]               cfg_addr,
   input  logic [PHASE_W-1:0]       cfg_wdata,
   input  logic signed [FM_W-1:0]   fm_ofs,
   input  logic signed [SAMP_W-1:0] am_scale,
   input  logic                     s_valid,
   input  logic [SAMP_W-1:0]        s_data,
   output logic                     s_ready,
   output logic signed [SAMP_W-1:0] sample_out,
   output logic                     underflow
);
   localparam int SH_W = $clog2(BUF_LOG2 + 1);
   localparam logic [BUF_LOG2-1:0] ADDR_ONES = '1;

   generate
      if (BUF_LOG2 < MIN_LOG2 || BUF_LOG2 > MIN_LOG2 + 3) begin : g_bad_buf
         $error("BUF_LOG2 must lie within MIN_LOG2 .. MIN_LOG2+3");
      end
      if (FM_W >= PHASE_W || SAMP_W > PHASE_W || BUF_LOG2 >= PHASE_W) begin : g_bad_width
         $error("FM_W, SAMP_W and BUF_LOG2 must be narrower than PHASE_W");
      end
   endgenerate

   pb_mode_e              pend_mode, mode_q;
   logic [1:0]            pend_len, len_q;
   logic [PHASE_W-1:0]    tune_q;
   logic [BUF_LOG2-1:0]   widx_q;
   logic [BUF_LOG2-1:0]   rd_ptr;
   logic [BUF_LOG2-1:0]   len_last;
   logic [BUF_LOG2-1:0]   tbl_idx;
   logic [BUF_LOG2-1:0]   raddr;
   logic [SH_W-1:0]       shamt;
   logic [PHASE_W-1:0]    phase;
   logic                  wrap;
   logic [SAMP_W-1:0]     buf_rd;
   logic [SAMP_W-1:0]     stream_q;
   logic signed [SAMP_W-1:0] raw_smp;
   logic                  buf_we;

   // configuration words; control is held pending until restart
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_mode <= MODE_TABLE;
         pend_len  <= '0;
         mode_q    <= MODE_TABLE;
         len_q     <= '0;
         tune_q    <= '0;
         widx_q    <= '0;
      end else begin
         if (cfg_we) begin
            case (cfg_addr)
               CFG_CTRL: begin
                  pend_mode <= pb_mode_e'(cfg_wdata[1:0]);
                  pend_len  <= cfg_wdata[3:2];
               end
               CFG_TUNE: tune_q <= cfg_wdata;
               CFG_WIDX: widx_q <= cfg_wdata[BUF_LOG2-1:0];
               default:  widx_q <= widx_q + 1'b1;
            endcase
         end
         if (restart) begin
            mode_q <= pend_mode;
            len_q  <= pend_len;
         end
      end
   end

   assign buf_we = cfg_we && (cfg_addr == CFG_WDAT);

   always_comb begin
      if (MIN_LOG2 + int'(len_q) >= BUF_LOG2) shamt = '0;
      else shamt = SH_W'(BUF_LOG2 - MIN_LOG2 - int'(len_q));
      len_last = ADDR_ONES >> shamt;
      tbl_idx  = phase[PHASE_W-1 -: BUF_LOG2] >> shamt;
      raddr    = (mode_q == MODE_STEP) ? rd_ptr : tbl_idx;
   end

   dds_phase_acc #(.PHASE_W(PHASE_W), .FM_W(FM_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .clr(restart),
      .tune(tune_q), .fm_ofs(fm_ofs),
      .phase(phase), .wrap(wrap)
   );

   dds_wave_buf #(.ADDR_W(BUF_LOG2), .DATA_W(SAMP_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(restart),
      .we(buf_we), .waddr(widx_q), .wdata(cfg_wdata[SAMP_W-1:0]),
      .raddr(raddr), .rdata(buf_rd)
   );

   // per-carry read pointer for step mode
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       rd_ptr <= '0;
      else if (restart) rd_ptr <= '0;
      else if (mode_q == MODE_STEP && wrap)
         rd_ptr <= (rd_ptr == len_last) ? '0 : rd_ptr + 1'b1;
   end

   // stream capture on carry cycles only
   assign s_ready = wrap && (mode_q == MODE_STREAM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stream_q  <= '0;
         underflow <= 1'b0;
      end else if (restart) begin
         stream_q  <= '0;
         underflow <= 1'b0;
      end else if (s_ready) begin
         if (s_valid) stream_q  <= s_data;
         else         underflow <= 1'b1;
      end
   end

   assign raw_smp = (mode_q == MODE_STREAM) ? stream_q : buf_rd;

   dds_amp_scale #(.DATA_W(SAMP_W), .AM_EN(AM_EN)) u_amp (
      .clk(clk), .rst_n(rst_n), .clr(restart),
      .din(raw_smp), .scale(am_scale), .dout(sample_out)
   );
endmodule

// File: rtl/dds_playback_chk.sv
module dds_playback_chk #(
   parameter int PHASE_W  = 32,
   parameter int SAMP_W   = 16,
   parameter int BUF_LOG2 = 11
) (
   input logic                clk,
   input logic                rst_n,
   input logic                restart,
   input logic                s_ready,
   input logic                s_valid,
   input logic [SAMP_W-1:0]   s_data,
   input logic                underflow,
   input logic [SAMP_W-1:0]   raw_smp,
   input logic [PHASE_W-1:0]  phase,
   input logic [BUF_LOG2-1:0] rd_ptr,
   input logic [BUF_LOG2-1:0] len_last,
   input logic                wrap
);
   // R9
   restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (phase == '0 && rd_ptr == '0 && !underflow));

   // R6
   underflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (underflow && !restart) |=> underflow);

   // R6
   underflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ready && !s_valid && !restart) |=> underflow);

   // R5
   stream_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s_ready && s_valid && !restart) |=> (raw_smp == $past(s_data)));

   // R4
   ptr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ptr <= len_last);

   // R4
   ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !wrap) |=> $stable(rd_ptr));
endmodule

bind dds_playback_engine dds_playback_chk #(
   .PHASE_W(PHASE_W), .SAMP_W(SAMP_W), .BUF_LOG2(BUF_LOG2)
) u_chk (
   .clk(clk), .rst_n(rst_n), .restart(restart),
   .s_ready(s_ready), .s_valid(s_valid), .s_data(s_data),
   .underflow(underflow), .raw_smp(raw_smp), .phase(phase),
   .rd_ptr(rd_ptr), .len_last(len_last), .wrap(wrap)
);

// File: tb/dds_playback_engine_tb.sv
`timescale 1ns/1ps
module dds_playback_engine_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic restart = 1'b0;
   logic cfg_we = 1'b0;
   logic [1:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic signed [15:0] fm_ofs = '0;
   logic signed [15:0] am_scale = 16'sh7FFF;
   logic s_valid = 1'b0;
   logic [15:0] s_data = '0;
   logic s_ready;
   logic signed [15:0] sample_out;
   logic underflow;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   dds_playback_engine u_dut (
      .clk(clk), .rst_n(rst_n), .restart(restart),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .fm_ofs(fm_ofs), .am_scale(am_scale),
      .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
      .sample_out(sample_out), .underflow(underflow)
   );

   function automatic logic signed [15:0] val(int i);
      if (i == 0) return -16'sd32768;
      return 16'(i * 11 - 9000);
   endfunction

   function automatic logic signed [15:0] amf(logic signed [15:0] x, logic signed [15:0] s);
      longint p;
      p = longint'(x) * longint'(s) + 64'sd16384;
      p = p >>> 15;
      if (p > 32767) return 16'sh7FFF;
      if (p < -32768) return -16'sd32768;
      return p[15:0];
   endfunction

   task automatic chk(string req, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cfg_write(logic [1:0] a, logic [31:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(posedge clk); @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_restart();
      restart = 1'b1;
      @(posedge clk); @(negedge clk);
      restart = 1'b0;
   endtask

   task automatic setup(logic [1:0] mode, logic [1:0] code, logic [31:0] tw,
                        logic signed [15:0] fm, logic signed [15:0] am);
      cfg_write(2'd0, {28'd0, code, mode});
      cfg_write(2'd1, tw);
      fm_ofs = fm; am_scale = am;
      do_restart();
   endtask

   function automatic logic [31:0] step_of(logic [31:0] tw, logic signed [15:0] fm);
      return tw + {{16{fm[15]}}, fm};
   endfunction

   // wavetable check; optional control write mid-run that must not take effect
   task automatic run_table(string req, int code, logic [31:0] step, int ncyc, bit poke);
      int L;
      L = (10 + code > 11) ? 11 : 10 + code;
      for (int n = 1; n <= ncyc; n++) begin
         @(posedge clk); @(negedge clk);
         if (poke && n == 50) begin cfg_we = 1'b1; cfg_addr = 2'd0; cfg_wdata = 32'h0000_0005; end
         if (poke && n == 51) cfg_we = 1'b0;
         if (n >= 3) begin
            logic [63:0] pr;
            logic [31:0] a;
            int idx;
            pr = 64'(n - 3) * 64'(step);
            a = pr[31:0];
            idx = int'(a >> (32 - L));
            chk(req, sample_out, amf(val(idx), am_scale));
         end
      end
   endtask

   task automatic test_reset();
      chk("R1 out in reset", sample_out, 0);
      chk("R1 underflow in reset", underflow, 0);
      chk("R1 ready in reset", s_ready, 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 out after reset", sample_out, 0);
      chk("R1 ready after reset", s_ready, 0);
   endtask

   task automatic load_buffer();
      cfg_write(2'd2, 32'd0);
      for (int i = 0; i < 2048; i++) cfg_write(2'd3, {16'd0, val(i)});
   endtask

   task automatic test_table_basic();
      setup(2'd0, 2'd0, 32'h0123_4567, 16'sd0, 16'sh7FFF);
      run_table("R2 R10 table len1024", 0, 32'h0123_4567, 600, 1'b0);
      setup(2'd3, 2'd0, 32'h0345_6789, 16'sd0, 16'sh7FFF);
      run_table("R10 mode3 acts as table", 0, 32'h0345_6789, 300, 1'b0);
   endtask

   task automatic test_lengths();
      setup(2'd0, 2'd1, 32'h00F0_0000, 16'sd0, 16'sh7FFF);
      run_table("R3 len code1", 1, 32'h00F0_0000, 400, 1'b0);
      setup(2'd0, 2'd3, 32'h00F0_0000, 16'sd0, 16'sh7FFF);
      run_table("R3 len code3 clamped", 3, 32'h00F0_0000, 400, 1'b0);
   endtask

   task automatic test_fm();
      setup(2'd0, 2'd0, 32'h0200_0000, -16'sd4660, 16'sh7FFF);
      run_table("R7 negative fm", 0, step_of(32'h0200_0000, -16'sd4660), 400, 1'b0);
      setup(2'd0, 2'd1, 32'h0100_0000, 16'sd30000, 16'sh7FFF);
      run_table("R7 positive fm", 1, step_of(32'h0100_0000, 16'sd30000), 400, 1'b0);
   endtask

   task automatic test_am();
      setup(2'd0, 2'd0, 32'h0456_0000, 16'sd0, 16'sh4000);
      run_table("R8 half scale rounding", 0, 32'h0456_0000, 300, 1'b0);
      setup(2'd0, 2'd0, 32'h0000_0000, 16'sd0, -16'sd32768);
      run_table("R8 saturation", 0, 32'h0, 20, 1'b0);
      chk("R8 saturated value", sample_out, 32767);
   endtask

   task automatic test_deferred();
      setup(2'd0, 2'd0, 32'h0777_0000, 16'sd0, 16'sh7FFF);
      run_table("R9 control deferred", 0, 32'h0777_0000, 300, 1'b1);
   endtask

   task automatic test_step();
      logic [31:0] tw;
      tw = 32'h9000_0000;
      setup(2'd1, 2'd0, tw, 16'sd0, 16'sh7FFF);
      for (int n = 1; n <= 3000; n++) begin
         @(posedge clk); @(negedge clk);
         if (n >= 4) begin
            logic [63:0] pr;
            int idx;
            pr = 64'(n - 4) * 64'(tw);
            idx = int'(pr[63:32]) % 1024;
            chk("R4 step mode wrap", sample_out, amf(val(idx), am_scale));
         end
      end
   endtask

   task automatic test_stream();
      logic [31:0] st;
      logic signed [15:0] rh0, rh1, rh2, rawnow, pdata;
      bit poffer, ptake, uexp;
      int offers;
      st = 32'h5000_0000;
      setup(2'd2, 2'd0, st, 16'sd0, 16'sh7FFF);
      rh0 = '0; rh1 = '0; rh2 = '0; pdata = '0;
      poffer = 1'b0; ptake = 1'b0; uexp = 1'b0; offers = 0;
      for (int n = 1; n <= 300; n++) begin
         logic [63:0] a1, a0;
         bit rdy;
         @(posedge clk); @(negedge clk);
         rawnow = ptake ? pdata : rh0;
         if (poffer && !ptake) uexp = 1'b1;
         rh2 = rh1; rh1 = rh0; rh0 = rawnow;
         if (n >= 2) chk("R5 stream output", sample_out, amf(rh2, am_scale));
         a1 = 64'(n) * 64'(st);
         a0 = 64'(n - 1) * 64'(st);
         rdy = (a1[63:32] != a0[63:32]);
         chk("R5 ready only on carry", s_ready, rdy);
         chk("R6 underflow sticky", underflow, uexp);
         poffer = rdy;
         if (rdy) begin
            ptake = (offers % 7) != 6;
            offers++;
            pdata = 16'(100 + offers * 37);
            s_valid = ptake;
            s_data = pdata;
         end else begin
            ptake = 1'b0;
            s_valid = n[0];
            s_data = 16'h7ABC;
         end
      end
      s_valid = 1'b0;
      chk("R6 underflow seen", underflow, 1);
      do_restart();
      chk("R9 restart clears underflow", underflow, 0);
      chk("R9 restart clears output", sample_out, 0);
   endtask

   task automatic test_1mhz();
      int wraps;
      logic signed [15:0] prev;
      wraps = 0; prev = '0;
      setup(2'd0, 2'd0, 32'd17179870, 16'sd0, 16'sh7FFF);
      for (int n = 1; n <= 2503; n++) begin
         @(posedge clk); @(negedge clk);
         if (n >= 4 && sample_out < prev) wraps++;
         prev = sample_out;
      end
      chk("R2 250-sample period", wraps, 10);
   endtask

   initial begin
      @(negedge clk);
      test_reset();
      load_buffer();
      test_table_basic();
      test_lengths();
      test_fm();
      test_am();
      test_deferred();
      test_step();
      test_stream();
      test_1mhz();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog (all requirements) actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule